// File: doc/BRIEF.md
# Serial Test Port Sequencer

This block is the sixteen-state sequencer at the heart of a serial test port. On every rising edge of the test clock it samples a single mode-select line and walks a fixed state graph. The graph has three parts: a reset/idle pair, a data-path branch and an instruction-path branch. Each branch has a selection state followed by capture, shift, exit, pause, second exit and update states. Downstream test logic uses the decoded strobes. Capture strobes load a register in parallel. Shift strobes move bits serially. Update strobes transfer the shifted value to the register's parallel outputs. A reset indication clears any test logic that depends on the port.

The block also drives the enable of the serial output driver. The enable is raised only in the two shift states, and it is retimed to the falling edge of the test clock so that it lines up with data that changes on that edge. An optional asynchronous active-low reset input forces the reset state at once. Without that input, holding mode-select high for five clock edges reaches the same state from anywhere. The instruction and data registers and any test instruments are outside this block.

Top module: `tpc_ctrl`

## Requirements
- R1: The `state` output uses this 4-bit encoding: 0 test-reset, 1 idle, 2 data-select, 3 data-capture, 4 data-shift, 5 data-exit1, 6 data-pause, 7 data-exit2, 8 data-update, 9 instr-select, 10 instr-capture, 11 instr-shift, 12 instr-exit1, 13 instr-pause, 14 instr-exit2, 15 instr-update. The state reads 0 while `trst_n` is held low.
- R2: From test-reset, mode-select 1 stays in test-reset and 0 goes to idle. From idle, 1 goes to data-select and 0 stays in idle.
- R3: Data branch transitions. Data-select goes to instr-select on 1 and to data-capture on 0. Capture goes to exit1 on 1 and to shift on 0. Shift stays on 0 and goes to exit1 on 1. Exit1 goes to update on 1 and to pause on 0. Pause stays on 0 and goes to exit2 on 1. Exit2 goes to update on 1 and back to shift on 0. Update goes to data-select on 1 and to idle on 0.
- R4: The instruction branch mirrors R3 state for state, with these differences. Instr-select goes to test-reset on 1 and to instr-capture on 0. Instr-update leaves to data-select on 1 and to idle on 0.
- R5: Five consecutive rising edges with mode-select high bring the state to test-reset from every one of the sixteen states.
- R6: `cap_dr`, `shf_dr` and `upd_dr` are high exactly in data-capture, data-shift and data-update. `cap_ir`, `shf_ir` and `upd_ir` are high exactly in instr-capture, instr-shift and instr-update. At most one of the six is high at a time.
- R7: `test_rst` is high exactly while the state is test-reset.
- R8: `tdo_en` is loaded on each falling edge of `tck` with 1 if the state is data-shift or instr-shift, and with 0 otherwise. It keeps that value through the following rising edge.
- R9: Driving `trst_n` low forces the state to test-reset and clears `tdo_en` without any clock edge. While `trst_n` stays low, clock edges do not move the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Optional asynchronous test reset, active low |
| tms | input | 1 | Mode-select, sampled on rising edge of tck |
| state | output | 4 | Current state, encoded as in R1 |
| test_rst | output | 1 | High in test-reset state |
| cap_dr | output | 1 | Data-capture strobe |
| shf_dr | output | 1 | Data-shift strobe |
| upd_dr | output | 1 | Data-update strobe |
| cap_ir | output | 1 | Instruction-capture strobe |
| shf_ir | output | 1 | Instruction-shift strobe |
| upd_ir | output | 1 | Instruction-update strobe |
| tdo_en | output | 1 | Serial output enable, changes on falling edge of tck |

## Verification
The state and every strobe derived from it are due in the same rising edge that samples mode-select, so the bench sets mode-select half a nanosecond after a falling edge and reads state, strobes and reset indication half a nanosecond after the next rising edge. The serial-output enable is due one half-cycle later, on the falling edge. The bench therefore checks it twice: just after the rising edge, where it must still reflect the previous state, and just after the falling edge, where it must reflect the new one. The asynchronous reset is checked a fraction of a nanosecond after it is asserted, with no clock edge in between.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  localparam int STW = 4;

  typedef enum logic [STW-1:0] {
    ST_RESET  = 4'd0,
    ST_IDLE   = 4'd1,
    ST_DR_SEL = 4'd2,
    ST_DR_CAP = 4'd3,
    ST_DR_SHF = 4'd4,
    ST_DR_EX1 = 4'd5,
    ST_DR_PAU = 4'd6,
    ST_DR_EX2 = 4'd7,
    ST_DR_UPD = 4'd8,
    ST_IR_SEL = 4'd9,
    ST_IR_CAP = 4'd10,
    ST_IR_SHF = 4'd11,
    ST_IR_EX1 = 4'd12,
    ST_IR_PAU = 4'd13,
    ST_IR_EX2 = 4'd14,
    ST_IR_UPD = 4'd15
  } tpc_state_e;

  function automatic tpc_state_e tpc_next_state(tpc_state_e s, logic m);
    tpc_state_e n;
    unique case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL: n = m ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP: n = m ? ST_DR_EX1 : ST_DR_SHF;
      ST_DR_SHF: n = m ? ST_DR_EX1 : ST_DR_SHF;
      ST_DR_EX1: n = m ? ST_DR_UPD : ST_DR_PAU;
      ST_DR_PAU: n = m ? ST_DR_EX2 : ST_DR_PAU;
      ST_DR_EX2: n = m ? ST_DR_UPD : ST_DR_SHF;
      ST_DR_UPD: n = m ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL: n = m ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP: n = m ? ST_IR_EX1 : ST_IR_SHF;
      ST_IR_SHF: n = m ? ST_IR_EX1 : ST_IR_SHF;
      ST_IR_EX1: n = m ? ST_IR_UPD : ST_IR_PAU;
      ST_IR_PAU: n = m ? ST_IR_EX2 : ST_IR_PAU;
      ST_IR_EX2: n = m ? ST_IR_UPD : ST_IR_SHF;
      ST_IR_UPD: n = m ? ST_DR_SEL : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

  function automatic logic tpc_is_shift(tpc_state_e s);
    return (s == ST_DR_SHF) || (s == ST_IR_SHF);
  endfunction

endpackage

// File: rtl/tpc_step.sv
module tpc_step
  import tpc_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tpc_state_e cur
);
  tpc_state_e nxt;

  always_comb nxt = tpc_next_state(cur, tms);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) cur <= ST_RESET;
    else        cur <= nxt;
  end
endmodule

// File: rtl/tpc_decode.sv
module tpc_decode
  import tpc_pkg::*;
(
  input  tpc_state_e cur,
  output logic       in_reset,
  output logic       cap_dr,
  output logic       shf_dr,
  output logic       upd_dr,
  output logic       cap_ir,
  output logic       shf_ir,
  output logic       upd_ir,
  output logic       shift_any
);
  always_comb begin
    in_reset  = (cur == ST_RESET);
    cap_dr    = (cur == ST_DR_CAP);
    shf_dr    = (cur == ST_DR_SHF);
    upd_dr    = (cur == ST_DR_UPD);
    cap_ir    = (cur == ST_IR_CAP);
    shf_ir    = (cur == ST_IR_SHF);
    upd_ir    = (cur == ST_IR_UPD);
    shift_any = tpc_is_shift(cur);
  end
endmodule

// File: rtl/tpc_oe.sv
module tpc_oe (
  input  logic tck,
  input  logic rst_n,
  input  logic shift_any,
  output logic oe
);
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) oe <= 1'b0;
    else        oe <= shift_any;
  end
endmodule

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
  import tpc_pkg::*;
#(
  parameter bit HAS_TRST = 1'b1
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           tms,
  output logic [STW-1:0] state,
  output logic           test_rst,
  output logic           cap_dr,
  output logic           shf_dr,
  output logic           upd_dr,
  output logic           cap_ir,
  output logic           shf_ir,
  output logic           upd_ir,
  output logic           tdo_en
);
  logic       rst_n;
  logic       shift_any;
  tpc_state_e cur;

  generate
    if (HAS_TRST) begin : g_trst
      assign rst_n = trst_n;
    end else begin : g_no_trst
      assign rst_n = 1'b1;
    end
  endgenerate

  tpc_step u_step (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .cur   (cur)
  );

  tpc_decode u_dec (
    .cur       (cur),
    .in_reset  (test_rst),
    .cap_dr    (cap_dr),
    .shf_dr    (shf_dr),
    .upd_dr    (upd_dr),
    .cap_ir    (cap_ir),
    .shf_ir    (shf_ir),
    .upd_ir    (upd_ir),
    .shift_any (shift_any)
  );

  tpc_oe u_oe (
    .tck       (tck),
    .rst_n     (rst_n),
    .shift_any (shift_any),
    .oe        (tdo_en)
  );

  assign state = cur;
endmodule

// File: rtl/tpc_ctrl_chk.sv
module tpc_ctrl_chk
  import tpc_pkg::*;
(
  input logic           tck,
  input logic           trst_n,
  input logic           tms,
  input logic [STW-1:0] state,
  input logic           test_rst,
  input logic           cap_dr,
  input logic           shf_dr,
  input logic           upd_dr,
  input logic           cap_ir,
  input logic           shf_ir,
  input logic           upd_ir,
  input logic           tdo_en
);
  logic [2:0] ones_run;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          ones_run <= 3'd0;
    else if (!tms)        ones_run <= 3'd0;
    else if (ones_run < 3'd5) ones_run <= ones_run + 3'd1;
  end

  AST_RESET_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET && tms) |=> state == ST_RESET); // R2
  AST_RESET_TO_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET && !tms) |=> state == ST_IDLE); // R2
  AST_DR_SHIFT_STAY: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_DR_SHF && !tms) |=> shf_dr); // R3
  AST_IR_SEL_ESCAPE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_IR_SEL && tms) |=> test_rst); // R4
  AST_FIVE_ONES: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_run == 3'd5) |-> state == ST_RESET); // R5
  AST_STROBE_ONEHOT: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir})); // R6
  AST_RESET_ENTRY: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(test_rst) |-> $past(tms)); // R7
  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (shf_dr || shf_ir)); // R8
endmodule

bind tpc_ctrl tpc_ctrl_chk u_chk (
  .tck      (tck),
  .trst_n   (trst_n),
  .tms      (tms),
  .state    (state),
  .test_rst (test_rst),
  .cap_dr   (cap_dr),
  .shf_dr   (shf_dr),
  .upd_dr   (upd_dr),
  .cap_ir   (cap_ir),
  .shf_ir   (shf_ir),
  .upd_ir   (upd_ir),
  .tdo_en   (tdo_en)
);

// File: tb/tpc_ctrl_tb.sv
`timescale 1ns/100ps
module tpc_ctrl_tb;
  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic [3:0] state;
  logic       test_rst, cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir, tdo_en;

  int checks = 0;
  int errors = 0;
  int cur = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  always #2 tck = ~tck;

  tpc_ctrl u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
    .test_rst(test_rst), .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
    .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir), .tdo_en(tdo_en)
  );

  // Data branch table; instruction branch is the same shifted by 7.
  function automatic int dr_next(int s, bit m);
    case (s)
      3: return m ? 5 : 4;
      4: return m ? 5 : 4;
      5: return m ? 8 : 6;
      6: return m ? 7 : 6;
      7: return m ? 8 : 4;
      default: return m ? 2 : 1;
    endcase
  endfunction

  function automatic int model_next(int s, bit m);
    if (s == 0) return m ? 0 : 1;
    if (s == 1) return m ? 2 : 1;
    if (s == 2) return m ? 9 : 3;
    if (s == 9) return m ? 0 : 10;
    if (s >= 10) begin
      int n = dr_next(s - 7, m);
      return (n >= 3) ? n + 7 : n;
    end
    return dr_next(s, m);
  endfunction

  function automatic bit is_shift(int s);
    return (s == 4) || (s == 11);
  endfunction

  function automatic string tag_of(int s);
    if (s <= 1) return "R2";
    if (s <= 8) return "R3";
    return "R4";
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk(tag_of(cur), int'(state), cur);
    chk("R6", int'({cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir}),
        int'({cur == 3, cur == 4, cur == 8, cur == 10, cur == 11, cur == 15}));
    chk("R7", int'(test_rst), int'(cur == 0));
  endtask

  task automatic step(bit m);
    int prev;
    @(negedge tck); #0.5;
    chk("R8", int'(tdo_en), int'(is_shift(cur)));
    tms = m;
    prev = cur;
    @(posedge tck); #0.5;
    cur = model_next(cur, m);
    check_outputs();
    chk("R8", int'(tdo_en), int'(is_shift(prev)));
  endtask

  function automatic bit next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: reset value while trst_n low
    #3;
    chk("R1", int'(state), 0);
    chk("R9", int'(tdo_en), 0);
    chk("R7", int'(test_rst), 1);
    @(negedge tck); #0.5;
    trst_n = 1'b1;
    cur = 0;

    // R2/R3/R4 directed walk over both branches
    step(1); step(0); step(1); step(0); step(0); step(0); step(1); step(0);
    step(0); step(1); step(0); step(1); step(1); step(1); step(1); step(0);
    step(0); step(0); step(1); step(1); step(0); step(1); step(0); step(0);
    step(1); step(1); step(1); step(0);

    // R5: five ones from each of the sixteen states
    for (int t = 0; t < 16; t++) begin
      for (int k = 0; k < 5; k++) step(1);
      for (int k = 0; k < 400 && cur != t; k++) step(next_rand());
      chk("R5", cur, t);
      for (int k = 0; k < 5; k++) step(1);
      chk("R5", int'(state), 0);
    end

    // Pseudo-random sweep covers every transition of R2/R3/R4
    for (int k = 0; k < 4000; k++) step(next_rand());

    // R9: async reset in data-shift
    for (int k = 0; k < 5; k++) step(1);
    step(0); step(1); step(0); step(0); step(0);
    chk("R3", cur, 4);
    @(negedge tck); #0.5;
    chk("R8", int'(tdo_en), 1);
    #0.5;
    trst_n = 1'b0;
    #0.3;
    chk("R9", int'(state), 0);
    chk("R9", int'(tdo_en), 0);
    tms = 1'b0;
    @(posedge tck); #0.5;
    chk("R9", int'(state), 0);
    @(negedge tck); #0.5;
    chk("R9", int'(tdo_en), 0);
    trst_n = 1'b1;
    cur = 0;
    step(0); step(1);
    finish_run();
  end
endmodule